// File: doc/BRIEF.md
# UART Oversample and Bit-Rate Tick Generator

This block turns a system clock into the timing pulses a UART's serial shifters run on. A two-stage divider, made of a small prescaler followed by a wider divisor counter, produces a one-clock oversample tick. A phase counter then picks every thirteenth of those ticks as a bit-rate strobe. Both divider settings are written through a single configuration word. Each field holds its value minus one, so the oversample period in system clocks is (prescaler field + 1) × (divisor field + 1).

A new setting is never applied in the middle of a period. The written value waits in a shadow copy, and a busy flag in the status word stays high until the divider reaches its next terminal count. At that count the shadow copy becomes the active setting and both counters load it. No shortened or stretched tick is ever produced. Driver code polls the busy flag before it writes again. When a receiver detects a start edge it pulses a realign input, and the bit-rate phase restarts from that point.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset both active fields are zero, the busy flag is low, the read-back word is zero, and `os_tick` is high on every clock, so the input clock passes through undivided.
- R2: The divisor-minus-one sits in bits 9:0 of the configuration word and the prescaler-minus-one in bits 19:16. Once adopted, a setting makes `os_tick` repeat every (prescaler field + 1) × (divisor field + 1) clocks, including the extremes 0/0 and 15/1023.
- R3: When the period is longer than one clock, `os_tick` is high for exactly one clock per period.
- R4: Bit 5 of `stat_o` is the busy flag. It is high from the clock after a write until the setting is adopted. All other `stat_o` bits read zero.
- R5: A written setting takes effect only at the next terminal count. The period that ends at the adopting tick keeps its old length. The busy flag falls and `cfg_rdata` changes in the same clock as that tick, and the period after it has the new length.
- R6: When several writes arrive while busy is high, only the most recent one is adopted.
- R7: Write-data bits outside bits 9:0 and 19:16 are ignored. They read back as zero and do not change the period.
- R8: `bit_tick` is high together with every 13th `os_tick` and never without `os_tick`.
- R9: A clock with `start_edge` high produces no `bit_tick` in the following cycle. It restarts the phase, so the next `bit_tick` comes with the 13th `os_tick` issued after that clock.
- R10: `cfg_rdata` returns the active (adopted) setting at the same field positions as the write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: divisor-1 at 9:0, prescaler-1 at 19:16 |
| start_edge | input | 1 | Receiver start-edge pulse that realigns the bit phase |
| cfg_rdata | output | 32 | Active setting read back at the write-field positions |
| stat_o | output | 8 | Status word, bit 5 high while an update is pending |
| os_tick | output | 1 | One-clock oversample tick |
| bit_tick | output | 1 | Bit-rate strobe, every 13th oversample tick |

## Verification
Every output is registered. A write shows as busy, and a start edge shows as a suppressed `bit_tick`, at the first sample after the capturing edge. An adoption shows in `os_tick`, `stat_o` and `cfg_rdata` at the same sample. The bench drives and samples on the falling edge and counts whole clocks between `os_tick` samples. It adds the cycles it spent before and during a write to the cycles until the adopting tick, and compares that total with the old period. It counts `os_tick` samples from the one after a start-edge capture onward to find the 13th.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
   localparam int unsigned DEF_PRE_W    = 4;
   localparam int unsigned DEF_DIV_W    = 10;
   localparam int unsigned DEF_REG_W    = 32;
   localparam int unsigned DEF_DIV_LSB  = 0;
   localparam int unsigned DEF_PRE_LSB  = 16;
   localparam int unsigned DEF_STAT_W   = 8;
   localparam int unsigned DEF_BUSY_BIT = 5;
   localparam int unsigned DEF_OS_RATE  = 13;

   // clocks per oversample tick for given minus-one fields
   function automatic int unsigned os_period(input int unsigned pre_m1,
                                             input int unsigned div_m1);
      return (pre_m1 + 1) * (div_m1 + 1);
   endfunction
endpackage

// File: rtl/uart_baud_regs.sv
module uart_baud_regs #(
   parameter int unsigned PRE_W   = 4,
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned REG_W   = 32,
   parameter int unsigned PRE_LSB = 16,
   parameter int unsigned DIV_LSB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             tc,
   output logic [PRE_W-1:0] act_pre,
   output logic [DIV_W-1:0] act_div,
   output logic [PRE_W-1:0] nxt_pre,
   output logic [DIV_W-1:0] nxt_div,
   output logic             busy
);
   logic [PRE_W-1:0] shd_pre;
   logic [DIV_W-1:0] shd_div;
   logic             adopt;

   assign adopt   = tc && busy;
   assign nxt_pre = busy ? shd_pre : act_pre;
   assign nxt_div = busy ? shd_div : act_div;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_pre <= '0;
         shd_div <= '0;
         act_pre <= '0;
         act_div <= '0;
         busy    <= 1'b0;
      end else begin
         if (adopt) begin
            act_pre <= shd_pre;
            act_div <= shd_div;
            busy    <= 1'b0;
         end
         if (wr_en) begin
            shd_pre <= wr_data[PRE_LSB +: PRE_W];
            shd_div <= wr_data[DIV_LSB +: DIV_W];
            busy    <= 1'b1;
         end
      end
   end

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tc) |=> busy); // R4
   AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && tc) |=> $stable({act_pre, act_div})); // R5
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(tc)); // R5
endmodule

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
   parameter int unsigned PRE_W = 4,
   parameter int unsigned DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] act_pre,
   input  logic [DIV_W-1:0] act_div,
   input  logic [PRE_W-1:0] nxt_pre,
   input  logic [DIV_W-1:0] nxt_div,
   output logic             tc,
   output logic             os_tick
);
   logic [PRE_W-1:0] pcnt;
   logic [DIV_W-1:0] dcnt;
   logic             pre_zero;

   assign pre_zero = (pcnt == '0);
   assign tc       = pre_zero && (dcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt    <= '0;
         dcnt    <= '0;
         os_tick <= 1'b0;
      end else begin
         os_tick <= tc;
         if (tc) begin
            pcnt <= nxt_pre;
            dcnt <= nxt_div;
         end else if (pre_zero) begin
            pcnt <= act_pre;
            dcnt <= dcnt - 1'b1;
         end else begin
            pcnt <= pcnt - 1'b1;
         end
      end
   end

   AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= act_pre); // R2
   AST_DCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt <= act_div); // R2
endmodule

// File: rtl/uart_baud_phase.sv
module uart_baud_phase #(
   parameter int unsigned OS_RATE = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tc,
   input  logic start_edge,
   output logic bit_tick
);
   localparam int unsigned OS_CW = (OS_RATE > 1) ? $clog2(OS_RATE) : 1;

   generate
      if (OS_RATE == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_tick <= 1'b0;
            else        bit_tick <= tc && !start_edge;
         end
      end else begin : g_count
         localparam logic [OS_CW-1:0] LAST = OS_CW'(OS_RATE - 1);
         logic [OS_CW-1:0] ocnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ocnt     <= '0;
               bit_tick <= 1'b0;
            end else begin
               bit_tick <= tc && !start_edge && (ocnt == LAST);
               if (start_edge)  ocnt <= '0;
               else if (tc)     ocnt <= (ocnt == LAST) ? '0 : ocnt + 1'b1;
            end
         end
         AST_OCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ocnt <= LAST); // R8
      end
   endgenerate
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
   import uart_baud_pkg::*;
#(
   parameter int unsigned PRE_W    = DEF_PRE_W,
   parameter int unsigned DIV_W    = DEF_DIV_W,
   parameter int unsigned REG_W    = DEF_REG_W,
   parameter int unsigned DIV_LSB  = DEF_DIV_LSB,
   parameter int unsigned PRE_LSB  = DEF_PRE_LSB,
   parameter int unsigned STAT_W   = DEF_STAT_W,
   parameter int unsigned BUSY_BIT = DEF_BUSY_BIT,
   parameter int unsigned OS_RATE  = DEF_OS_RATE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              start_edge,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [STAT_W-1:0] stat_o,
   output logic              os_tick,
   output logic              bit_tick
);
   generate
      if (PRE_LSB < DIV_LSB + DIV_W) begin : g_chk_overlap
         $error("prescaler field overlaps divisor field");
      end
      if (PRE_LSB + PRE_W > REG_W) begin : g_chk_fit
         $error("prescaler field exceeds register width");
      end
      if (BUSY_BIT >= STAT_W) begin : g_chk_busy
         $error("busy bit outside status word");
      end
      if (OS_RATE < 1) begin : g_chk_rate
         $error("oversample rate must be at least one");
      end
   endgenerate

   logic [PRE_W-1:0] act_pre, nxt_pre;
   logic [DIV_W-1:0] act_div, nxt_div;
   logic             busy, tc;

   uart_baud_regs #(.PRE_W(PRE_W), .DIV_W(DIV_W), .REG_W(REG_W),
                    .PRE_LSB(PRE_LSB), .DIV_LSB(DIV_LSB)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata), .tc(tc),
      .act_pre(act_pre), .act_div(act_div), .nxt_pre(nxt_pre),
      .nxt_div(nxt_div), .busy(busy));

   uart_baud_div #(.PRE_W(PRE_W), .DIV_W(DIV_W)) div_i (
      .clk(clk), .rst_n(rst_n), .act_pre(act_pre), .act_div(act_div),
      .nxt_pre(nxt_pre), .nxt_div(nxt_div), .tc(tc), .os_tick(os_tick));

   uart_baud_phase #(.OS_RATE(OS_RATE)) phase_i (
      .clk(clk), .rst_n(rst_n), .tc(tc), .start_edge(start_edge),
      .bit_tick(bit_tick));

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[DIV_LSB +: DIV_W] = act_div;
      cfg_rdata[PRE_LSB +: PRE_W] = act_pre;
      stat_o = '0;
      stat_o[BUSY_BIT] = busy;
   end

   AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> stat_o[BUSY_BIT]); // R4
   AST_BIT_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick); // R8
   AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      start_edge |=> !bit_tick); // R9
endmodule

// File: tb/uart_baud_gen_tb_top.sv
`timescale 1ns/1ps
module uart_baud_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        start_edge = 1'b0;
   logic [31:0] cfg_rdata;
   logic [7:0]  stat_o;
   logic        os_tick, bit_tick;

   int n_chk = 0;
   int n_fail = 0;
   int unsigned cyc_cnt = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   uart_baud_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .start_edge(start_edge), .cfg_rdata(cfg_rdata), .stat_o(stat_o),
      .os_tick(os_tick), .bit_tick(bit_tick));

   function automatic logic [31:0] mk(input int unsigned p, input int unsigned d);
      return (32'(p & 15) << 16) | 32'(d & 1023);
   endfunction

   function automatic int unsigned per(input int unsigned p, input int unsigned d);
      return (p + 1) * (d + 1);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] w);
      cfg_we = 1'b1;
      cfg_wdata = w;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic wait_tick(output int unsigned n);
      n = 0;
      do begin
         cyc();
         n++;
      end while (!os_tick && n < 20000);
      if (n >= 20000) chk(1'b0, "R2 tick timeout", n, 0);
   endtask

   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (cyc_cnt == 190000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=finish", cyc_cnt);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int unsigned n, tot, p, d, cnt;
      bit seen;
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      chk(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
      chk(stat_o == 0, "R1 status", stat_o, 0);
      for (int i = 0; i < 5; i++) begin
         chk(os_tick == 1'b1, "R1 undivided tick", os_tick, 1);
         cyc();
      end
      // R2/R4/R5/R10 directed setting 2/4
      wr(mk(2, 4));
      chk(stat_o == 8'h20, "R4 busy set", stat_o, 8'h20);
      wait_tick(n);
      chk(stat_o == 0, "R5 busy clear at adopt", stat_o, 0);
      chk(cfg_rdata == mk(2, 4), "R10 readback", cfg_rdata, mk(2, 4));
      cyc();
      chk(os_tick == 1'b0, "R3 one clock pulse", os_tick, 0);
      wait_tick(n);
      chk(n == 15 - 1 + 0 || n == 14, "R2 period 15 partial", n, 14);
      wait_tick(n);
      chk(n == 15, "R2 period 15", n, 15);
      // R5 old period kept through adoption
      repeat (6) cyc();
      wr(mk(0, 1));
      chk(cfg_rdata == mk(2, 4), "R5 rdata holds old", cfg_rdata, mk(2, 4));
      chk(stat_o[5] == 1'b1, "R4 busy pending", stat_o[5], 1);
      wait_tick(n);
      tot = 6 + 1 + n;
      chk(tot == 15, "R5 no shortened tick", tot, 15);
      wait_tick(n);
      chk(n == 2, "R5 new period", n, 2);
      // R6 latest write wins
      wr(mk(3, 9));
      wait_tick(n);
      wait_tick(n);
      chk(n == 40, "R2 period 40", n, 40);
      repeat (3) cyc();
      wr(mk(1, 1));
      wr(mk(0, 5));
      wait_tick(n);
      chk(cfg_rdata == mk(0, 5), "R6 latest adopted", cfg_rdata, mk(0, 5));
      wait_tick(n);
      chk(n == 6, "R6 period", n, 6);
      // R7 ignored bits
      wr(32'hFFF0_FC03);
      wait_tick(n);
      chk(cfg_rdata == 32'h0000_0003, "R7 readback", cfg_rdata, 32'h3);
      wait_tick(n);
      chk(n == 4, "R7 period", n, 4);
      // R8 bit strobe every 13th tick
      cnt = 0;
      while (!bit_tick && cnt < 2000) begin cyc(); cnt++; end
      for (int k = 0; k < 3; k++) begin
         cnt = 0;
         seen = 1'b0;
         while (!seen && cnt < 100) begin
            cyc();
            if (os_tick) cnt++;
            if (bit_tick) seen = 1'b1;
         end
         chk(cnt == 13, "R8 ticks per bit", cnt, 13);
         chk(os_tick == 1'b1, "R8 bit with tick", os_tick, 1);
      end
      // R9 realign on start edge
      repeat (4) wait_tick(n);
      repeat (2) cyc();
      start_edge = 1'b1;
      cyc();
      start_edge = 1'b0;
      chk(bit_tick == 1'b0, "R9 quiet after start", bit_tick, 0);
      cnt = 0;
      seen = 1'b0;
      while (!seen && cnt < 100) begin
         cyc();
         if (os_tick) cnt++;
         if (bit_tick) seen = 1'b1;
      end
      chk(cnt == 13, "R9 realigned phase", cnt, 13);
      // R2 maximum setting
      wr(mk(15, 1023));
      wait_tick(n);
      wait_tick(n);
      chk(n == 16384, "R2 max period", n, 16384);
      // random settings
      for (int it = 0; it < 8; it++) begin
         p = $urandom % 16;
         d = $urandom % 24;
         repeat ($urandom % 8) cyc();
         wr(mk(p, d) | (32'($urandom) & 32'hFFF0_FC00));
         chk(stat_o[5] == 1'b1, "R4 random busy", stat_o[5], 1);
         wait_tick(n);
         chk(stat_o == 0, "R5 random adopt", stat_o, 0);
         chk(cfg_rdata == mk(p, d), "R10 random readback", cfg_rdata, mk(p, d));
         wait_tick(n);
         chk(n == per(p, d), "R2 random period", n, per(p, d));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule